// File: doc/BRIEF.md
# SPI EEPROM Slave Command Front End

This block is the serial slave side of a byte-wide nonvolatile memory. A host drives a four-wire SPI link (select, clock, data in, data out) in mode 0 or mode 3. Each transfer carries an 8-bit command code, a 24-bit byte address and then data bytes. The block decodes the command and either stores incoming bytes into a small internal byte array or shifts stored bytes back out. The array stands in for the real memory cells. The address advances after every data byte, so one transfer can stream many bytes.

All link pins are brought into the system clock domain through a configurable synchronizer, and edges of the serial clock are detected there. A pause input can freeze a transfer in the middle without losing its place. A command code the block does not know silences it until the host deselects it and selects it again. The serial output is modelled as a data bit plus an output-enable flag, so no bidirectional pin is needed.

Top module: `spi_ee_slave`

## Requirements
- R1: Data in is sampled on rising serial-clock edges and data out changes only on falling edges. Transfers work with the clock idling low (mode 0) and with it idling high (mode 3).
- R2: Command, address and data bytes travel most significant bit first, in both directions.
- R3: While the select input is high, miso_oe stays 0 and clock and data-in activity changes no stored byte.
- R4: The first byte of a transfer is the command: 0x03 reads and 0x02 writes. A 24-bit address follows, MSB first. Only its low MEM_AW bits (10 by default) pick the array entry, and the upper bits are ignored.
- R5: Any other command byte keeps miso_oe at 0 and blocks all writes for the rest of that transfer. The next transfer is decoded normally.
- R6: In a read, the first data bit is driven on the first falling clock edge after the 32nd rising edge. miso_oe is 0 during the command and address bytes and 1 from then until deselect.
- R7: A continuous read moves to the next address after each byte and wraps from entry 2^MEM_AW-1 to entry 0.
- R8: In a write, each complete data byte is stored at the current address, which then advances with the same wrap. A final byte with fewer than 8 bits before deselect is dropped.
- R9: Pause starts when hold_n falls while the clock is low and ends when hold_n rises while the clock is low. During a pause, miso_oe is 0 and clock edges and data-in are ignored.
- R10: After a pause, the transfer continues at the same bit, byte and address, and miso_oe returns to 1 for a read.
- R11: After reset, miso_oe is 0 and the block waits for a command byte.
- R12: Deselecting in the middle of the command or address bytes abandons that command, and the next transfer starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select; frames each transfer |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Active-low pause request |
| spi_miso | output | 1 | Serial data to the host (valid when miso_oe is 1) |
| spi_miso_oe | output | 1 | Output enable; 0 means the line is released |

## Verification
The hardest state to reach from the ports is a pause taken in the middle of a byte. It has to be entered with the clock low, and it has to see clock and data toggling while frozen. The stimulus stops a read after three data bits and a write after five. It lowers the clock, pulls hold_n low and toggles the clock with junk on data-in. It then raises hold_n with the clock low and finishes the byte. The bench checks that the read byte and the following byte come out intact, and reads the written byte back. Address wrap and dropped partial bytes are reached by writing across the top entry and by deselecting after half a byte, then reading back in a separate transfer.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   // Transfer phase inside one selected frame.
   typedef enum logic [1:0] {
      PH_CMD    = 2'd0,
      PH_ADDR   = 2'd1,
      PH_DATA   = 2'd2,
      PH_LOCKED = 2'd3
   } phase_t;

   localparam logic [7:0] CMD_READ  = 8'h03;
   localparam logic [7:0] CMD_WRITE = 8'h02;

endpackage

// File: rtl/spi_ee_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
module spi_ee_sync #(
   parameter int unsigned        STAGES  = 2,
   parameter int unsigned        WIDTH   = 4,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("spi_ee_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[0] <= RST_VAL;
         else        stg_q[0] <= d;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q <= {STAGES{RST_VAL}};
         else        stg_q <= {stg_q[STAGES-2:0], d};
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_ee_hold.sv
// Pause tracker: enters and leaves only on hold_n edges seen while sck is low.
module spi_ee_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic sck,
   input  logic hold_n,
   output logic held
);

   logic hold_prev_q;
   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_prev_q <= 1'b1;
         held_q      <= 1'b0;
      end else begin
         hold_prev_q <= hold_n;
         if (!sel) begin
            held_q <= 1'b0;
         end else if (!held_q && hold_prev_q && !hold_n && !sck) begin
            held_q <= 1'b1;
         end else if (held_q && !hold_prev_q && hold_n && !sck) begin
            held_q <= 1'b0;
         end
      end
   end

   assign held = held_q;

endmodule

// File: rtl/spi_ee_mem.sv
// Stand-in byte array: synchronous write, combinational read.
module spi_ee_mem #(
   parameter int unsigned AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave #(
   parameter int unsigned ADDR_BITS   = 24,
   parameter int unsigned MEM_AW      = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  RD_CMD      = spi_ee_pkg::CMD_READ,
   parameter logic [7:0]  WR_CMD      = spi_ee_pkg::CMD_WRITE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   input  logic spi_hold_n,
   output logic spi_miso,
   output logic spi_miso_oe
);

   import spi_ee_pkg::*;

   localparam int unsigned ADDR_BYTES = ADDR_BITS / 8;
   localparam int unsigned AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam logic [AB_W-1:0]   AB_LAST = AB_W'(ADDR_BYTES - 1);
   localparam logic [MEM_AW-1:0] A_ONE   = MEM_AW'(1);

   if (ADDR_BITS % 8 != 0 || ADDR_BITS < 16) begin : g_bad_addr
      $error("spi_ee_slave: ADDR_BITS must be a multiple of 8 and at least 16");
   end
   if (MEM_AW < 1 || MEM_AW > ADDR_BITS) begin : g_bad_mem
      $error("spi_ee_slave: MEM_AW must lie in 1..ADDR_BITS");
   end
   if (RD_CMD == WR_CMD) begin : g_bad_cmd
      $error("spi_ee_slave: read and write command codes must differ");
   end

   // ---------------- input synchronization ----------------
   logic [3:0] pins_raw, pins_s;
   logic       cs_n_s, sck_s, hold_n_s, mosi_s;

   assign pins_raw = {spi_cs_n, spi_sck, spi_hold_n, spi_mosi};

   spi_ee_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (4),
      .RST_VAL (4'b1010)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign {cs_n_s, sck_s, hold_n_s, mosi_s} = pins_s;

   logic sel;
   assign sel = !cs_n_s;

   // ---------------- pause tracking ----------------
   logic held;

   spi_ee_hold hold_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .sck    (sck_s),
      .hold_n (hold_n_s),
      .held   (held)
   );

   // ---------------- clock edge detection ----------------
   logic sck_prev_q;
   logic sck_rise, sck_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev_q <= 1'b0;
      else        sck_prev_q <= sck_s;
   end

   assign sck_rise = sel && !held &&  sck_s && !sck_prev_q;
   assign sck_fall = sel && !held && !sck_s &&  sck_prev_q;

   // ---------------- command engine state ----------------
   phase_t                phase_q;
   logic                  is_read_q;
   logic [2:0]            bit_cnt_q;
   logic [6:0]            shift_q;
   logic [AB_W-1:0]       abyte_q;
   logic [ADDR_BITS-1:0]  addr_q;
   logic                  miso_q;
   logic                  oe_q;

   logic [7:0]            byte_in;
   logic                  byte_done;
   logic [7:0]            rd_byte;
   logic                  mem_we;

   assign byte_in   = {shift_q, mosi_s};
   assign byte_done = sck_rise && (phase_q != PH_LOCKED) && (bit_cnt_q == 3'd7);
   assign mem_we    = byte_done && (phase_q == PH_DATA) && !is_read_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_CMD;
         is_read_q <= 1'b0;
         bit_cnt_q <= 3'd0;
         shift_q   <= '0;
         abyte_q   <= '0;
         addr_q    <= '0;
         miso_q    <= 1'b0;
         oe_q      <= 1'b0;
      end else if (!sel) begin
         phase_q   <= PH_CMD;
         bit_cnt_q <= 3'd0;
         abyte_q   <= '0;
         oe_q      <= 1'b0;
      end else if (sck_rise && phase_q != PH_LOCKED) begin
         shift_q   <= byte_in[6:0];
         bit_cnt_q <= bit_cnt_q + 3'd1;
         if (bit_cnt_q == 3'd7) begin
            unique case (phase_q)
               PH_CMD: begin
                  if (byte_in == RD_CMD) begin
                     is_read_q <= 1'b1;
                     phase_q   <= PH_ADDR;
                  end else if (byte_in == WR_CMD) begin
                     is_read_q <= 1'b0;
                     phase_q   <= PH_ADDR;
                  end else begin
                     phase_q   <= PH_LOCKED;
                  end
               end
               PH_ADDR: begin
                  addr_q  <= {addr_q[ADDR_BITS-9:0], byte_in};
                  abyte_q <= abyte_q + AB_W'(1);
                  if (abyte_q == AB_LAST) phase_q <= PH_DATA;
               end
               PH_DATA: begin
                  addr_q[MEM_AW-1:0] <= addr_q[MEM_AW-1:0] + A_ONE;
               end
               default: phase_q <= PH_LOCKED;
            endcase
         end
      end else if (sck_fall && phase_q == PH_DATA && is_read_q) begin
         miso_q <= rd_byte[3'd7 - bit_cnt_q];
         oe_q   <= 1'b1;
      end
   end

   // ---------------- stand-in array ----------------
   spi_ee_mem #(
      .AW (MEM_AW)
   ) mem_i (
      .clk   (clk),
      .we    (mem_we),
      .waddr (addr_q[MEM_AW-1:0]),
      .wdata (byte_in),
      .raddr (addr_q[MEM_AW-1:0]),
      .rdata (rd_byte)
   );

   assign spi_miso_oe = oe_q && sel && !held;
   assign spi_miso    = spi_miso_oe ? miso_q : 1'b0;

endmodule

// File: rtl/spi_ee_slave_chk.sv
// Property checker bound into spi_ee_slave.
// phase encoding: 0 command, 1 address, 2 data, 3 locked.
module spi_ee_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sel,
   input logic       held,
   input logic [1:0] phase,
   input logic [2:0] bit_cnt,
   input logic       miso_oe,
   input logic       mem_we
);

   AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !miso_oe);  // R3

   AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !mem_we);  // R3

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && phase == 2'd3) |=> (!sel || phase == 2'd3));  // R5

   AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'd3) |-> (!miso_oe && !mem_we));  // R5

   AST_OE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> (phase == 2'd2));  // R6

   AST_HOLD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !miso_oe);  // R9

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !mem_we);  // R9

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && held) |=> (!sel || ($stable(bit_cnt) && $stable(phase))));  // R10

endmodule

bind spi_ee_slave spi_ee_slave_chk chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel     (sel),
   .held    (held),
   .phase   (phase_q),
   .bit_cnt (bit_cnt_q),
   .miso_oe (spi_miso_oe),
   .mem_we  (mem_we)
);

// File: tb/spi_ee_slave_tb_top.sv
`timescale 1ns/1ps
module spi_ee_slave_tb_top;

   localparam int MEM_AW = 10;
   localparam int DEPTH  = 1 << MEM_AW;
   localparam int HALF   = 8;

   // {24-bit address, data byte}; some addresses alias through the upper bits (R4)
   localparam logic [31:0] VEC [0:5] = '{
      {24'h000000, 8'h5A},
      {24'h000001, 8'hC3},
      {24'h0003FF, 8'h81},
      {24'h120200, 8'h3C},
      {24'h000155, 8'hF0},
      {24'hFFFC10, 8'h0F}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic hold_n = 1'b1;
   logic miso, miso_oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic idle_hi = 1'b0;

   logic [7:0] exp_mem [DEPTH];
   logic [7:0] wbuf [8];

   always #2 clk = ~clk;

   spi_ee_slave #(.MEM_AW(MEM_AW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_cs_n    (cs_n),
      .spi_sck     (sck),
      .spi_mosi    (mosi),
      .spi_hold_n  (hold_n),
      .spi_miso    (miso),
      .spi_miso_oe (miso_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic sbit(input logic b, output logic r, output logic oe);
      sck = 1'b0; mosi = b; tick(HALF);
      r = miso; oe = miso_oe;
      sck = 1'b1; tick(HALF);
   endtask

   task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx,
                        output logic all_oe, output logic any_oe);
      logic r, o;
      all_oe = 1'b1; any_oe = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         sbit(tx[i], r, o);
         rx[i] = r; all_oe &= o; any_oe |= o;
      end
   endtask

   task automatic fstart();
      sck = idle_hi; tick(HALF); cs_n = 1'b0; tick(HALF);
   endtask

   task automatic fstop();
      sck = idle_hi; tick(HALF); cs_n = 1'b1; tick(HALF);
   endtask

   task automatic send_hdr(input logic [7:0] cmd, input logic [23:0] a, output logic any_oe);
      logic [7:0] rx; logic ao, no;
      sbyte(cmd, rx, ao, no); any_oe = no;
      sbyte(a[23:16], rx, ao, no); any_oe |= no;
      sbyte(a[15:8], rx, ao, no);  any_oe |= no;
      sbyte(a[7:0], rx, ao, no);   any_oe |= no;
   endtask

   task automatic wr_frame(input logic [23:0] a, input int n);
      logic [7:0] rx; logic ao, no;
      fstart();
      send_hdr(8'h02, a, no);
      for (int k = 0; k < n; k++) begin
         sbyte(wbuf[k], rx, ao, no);
         exp_mem[(int'(a) + k) % DEPTH] = wbuf[k];
      end
      fstop();
   endtask

   task automatic rd_frame(input logic [23:0] a, input int n, input string tag);
      logic [7:0] rx; logic ao, no;
      fstart();
      send_hdr(8'h03, a, no);
      chk({tag, " R6 oe low in header"}, no, 1'b0);
      for (int k = 0; k < n; k++) begin
         sbyte(8'h00, rx, ao, no);
         chk({tag, " R2 data"}, rx, exp_mem[(int'(a) + k) % DEPTH]);
         chk({tag, " R6 oe high in data"}, ao, 1'b1);
      end
      fstop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] rx;
      logic ao, no, tr, to;

      tick(5);
      chk("R11 oe in reset", miso_oe, 1'b0);
      rst_n = 1'b1;
      tick(5);
      chk("R11 oe after reset", miso_oe, 1'b0);

      // Table walk: write each entry, alternating clock idle level (R1, R4, R8)
      for (int i = 0; i < 6; i++) begin
         idle_hi = i[0];
         wbuf[0] = VEC[i][7:0];
         wr_frame(VEC[i][31:8], 1);
      end
      // Read each back at the aliased-down address with the other idle level (R1, R2, R4, R6)
      for (int i = 0; i < 6; i++) begin
         idle_hi = ~i[0];
         rd_frame({14'd0, VEC[i][MEM_AW+7:8]}, 1, "R4 table");
      end

      // R3: activity while deselected
      idle_hi = 1'b0;
      for (int k = 0; k < 16; k++) begin
         mosi = k[1]; sck = ~sck; tick(HALF);
         chk("R3 oe while deselected", miso_oe, 1'b0);
      end
      sck = 1'b0; tick(HALF);
      rd_frame(24'h000000, 1, "R3 no write while deselected");

      // R5: unknown command, then a write sequence inside the same frame
      fstart();
      sbyte(8'hA5, rx, ao, no); tr = no;
      sbyte(8'h02, rx, ao, no); tr |= no;
      sbyte(8'h00, rx, ao, no); tr |= no;
      sbyte(8'h00, rx, ao, no); tr |= no;
      sbyte(8'h00, rx, ao, no); tr |= no;
      sbyte(8'h77, rx, ao, no); tr |= no;
      sbyte(8'h00, rx, ao, no); tr |= no;
      fstop();
      chk("R5 oe stays low after unknown command", tr, 1'b0);
      rd_frame(24'h000000, 1, "R5 next frame decodes");

      // R7/R8: multi-byte write across the top of the array, read across the wrap
      idle_hi = 1'b1;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      wr_frame(24'h0003FE, 3);
      idle_hi = 1'b0;
      rd_frame(24'h0003FE, 4, "R7 wrap read");

      // R8: partial final byte dropped
      wbuf[0] = 8'h44; wbuf[1] = 8'h99;
      wr_frame(24'h000100, 2);
      fstart();
      send_hdr(8'h02, 24'h000101, no);
      sbit(1'b1, tr, to); sbit(1'b1, tr, to); sbit(1'b1, tr, to); sbit(1'b0, tr, to);
      fstop();
      rd_frame(24'h000100, 2, "R8 partial byte dropped");

      // R12: abandon a command in the address bytes
      fstart();
      sbyte(8'h02, rx, ao, no);
      sbyte(8'h00, rx, ao, no);
      fstop();
      rd_frame(24'h000001, 1, "R12 after abandoned command");

      // R9/R10: pause in the middle of a read
      wbuf[0] = 8'hF0; wbuf[1] = 8'h0E; wbuf[2] = 8'h77;
      wr_frame(24'h000155, 3);
      fstart();
      send_hdr(8'h03, 24'h000155, no);
      for (int i = 7; i >= 5; i--) begin sbit(1'b0, tr, to); rx[i] = tr; end
      sck = 1'b0; tick(HALF);
      hold_n = 1'b0; tick(HALF);
      chk("R9 oe dropped in pause", miso_oe, 1'b0);
      for (int k = 0; k < 4; k++) begin
         mosi = k[0]; sck = 1'b1; tick(HALF);
         chk("R9 oe low while clock toggles in pause", miso_oe, 1'b0);
         sck = 1'b0; tick(HALF);
      end
      hold_n = 1'b1; tick(HALF);
      chk("R10 oe restored after pause", miso_oe, 1'b1);
      for (int i = 4; i >= 0; i--) begin sbit(1'b0, tr, to); rx[i] = tr; end
      chk("R10 read byte across pause", rx, 8'hF0);
      sbyte(8'h00, rx, ao, no);
      chk("R10 next byte after pause", rx, 8'h0E);
      fstop();

      // R9/R10: pause in the middle of a write, junk on data-in
      fstart();
      send_hdr(8'h02, 24'h000157, no);
      for (int i = 7; i >= 3; i--) sbit(8'hA9 >> i, tr, to);
      sck = 1'b0; tick(HALF);
      hold_n = 1'b0; tick(HALF);
      for (int k = 0; k < 4; k++) begin
         mosi = ~k[0]; sck = 1'b1; tick(HALF);
         sck = 1'b0; tick(HALF);
      end
      hold_n = 1'b1; tick(HALF);
      for (int i = 2; i >= 0; i--) sbit(8'hA9 >> i, tr, to);
      fstop();
      exp_mem[12'h157] = 8'hA9;
      idle_hi = 1'b1;
      rd_frame(24'h000157, 1, "R9 write across pause");

      finish_run();
   end

endmodule